// File: doc/BRIEF.md
# Eight-Bit Multi-Mode Shift and Count Register

The block holds one eight-bit word and, on every rising clock edge, applies the operation selected by a three-bit mode input. The operations are: hold, logical shift toward the least significant bit, logical shift toward the most significant bit, unsigned increment, unsigned decrement, rotation in either direction, and a parallel load taken from a shared bus. An active-low reset clears the word at once, without waiting for a clock edge.

The shared bus is split into three signals so that it can be simulated and synthesized without internal tri-states. `bus_in` carries what the bus holds, `bus_out` always carries the register value, and `bus_oe` enables an external tri-state driver. The unit drives the bus only when its output-control input is 1 and the mode is not the load mode. A load therefore always samples a value that another agent places on the bus.

Top module: `shift_count_reg`

## Requirements
- R1: While `arst_n` is 0, `bus_out` is 0 within the same clock period, whether or not a clock edge occurs.
- R2: Mode 3'b000 leaves the register unchanged across a clock edge.
- R3: Mode 3'b001 shifts toward bit 0 on each edge. The new bit 7 is 0 and bit 0 is discarded.
- R4: Mode 3'b010 shifts toward bit 7 on each edge. The new bit 0 is 0 and bit 7 is discarded.
- R5: Mode 3'b011 adds one modulo 256, so 8'hFF becomes 8'h00.
- R6: Mode 3'b100 subtracts one modulo 256, so 8'h00 becomes 8'hFF.
- R7: Mode 3'b101 rotates toward bit 0: old bit 0 becomes new bit 7.
- R8: Mode 3'b110 rotates toward bit 7: old bit 7 becomes new bit 0.
- R9: Mode 3'b111 loads `bus_in` into the register on the edge.
- R10: `bus_oe` is 1 exactly when `out_ctl` is 1 and `mode` is not 3'b111. It depends on these inputs alone, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| arst_n | input | 1 | Asynchronous reset, active low, clears the register |
| mode | input | 3 | Operation selected for the next edge |
| out_ctl | input | 1 | Permission for the unit to drive the shared bus |
| bus_in | input | W | Value currently present on the shared bus |
| bus_out | output | W | Register contents, the value driven when enabled |
| bus_oe | output | 1 | Enable for the external bus driver |

## Verification
The hardest situations to reach are the wrap-around edges: the increment from 8'hFF and the decrement from 8'h00, with the same value sitting one step from the opposite edge. They are reached by loading 8'hFF or 8'h00 over the bus in the load mode, then counting across the boundary in both directions. Long runs of random modes and bus values follow, and the output-enable rule is checked combinationally after each change of inputs. The reset is also pulsed low between clock edges, and the bench observes that the word clears before any edge arrives.

// File: rtl/shift_count_reg.sv
module shift_count_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [2:0]   mode,
  input  logic         out_ctl,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe
);
  localparam logic [2:0] M_HOLD = 3'b000;
  localparam logic [2:0] M_SHR  = 3'b001;
  localparam logic [2:0] M_SHL  = 3'b010;
  localparam logic [2:0] M_INC  = 3'b011;
  localparam logic [2:0] M_DEC  = 3'b100;
  localparam logic [2:0] M_ROR  = 3'b101;
  localparam logic [2:0] M_ROL  = 3'b110;
  localparam logic [2:0] M_LOAD = 3'b111;

  logic [W-1:0] q, nxt;

  always_comb begin
    case (mode)
      M_SHR:   nxt = {1'b0, q[W-1:1]};
      M_SHL:   nxt = {q[W-2:0], 1'b0};
      M_INC:   nxt = q + W'(1);
      M_DEC:   nxt = q - W'(1);
      M_ROR:   nxt = {q[0], q[W-1:1]};
      M_ROL:   nxt = {q[W-2:0], q[W-1]};
      M_LOAD:  nxt = bus_in;
      default: nxt = q;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) q <= '0;
    else         q <= nxt;

  assign bus_out = q;
  assign bus_oe  = out_ctl && (mode != M_LOAD);

  assert_reset_clear_R1: assert property (@(posedge clk) !arst_n |-> bus_out == '0);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_HOLD |=> bus_out == $past(bus_out));
  assert_shr_R3: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_SHR |=> !bus_out[W-1] && bus_out[W-2:0] == $past(bus_out[W-1:1]));
  assert_shl_R4: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_SHL |=> !bus_out[0] && bus_out[W-1:1] == $past(bus_out[W-2:0]));
  assert_inc_wrap_R5: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == M_INC && &bus_out) |=> bus_out == '0);
  assert_dec_wrap_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == M_DEC && bus_out == '0) |=> &bus_out);
  assert_ror_R7: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_ROR |=> bus_out[W-1] == $past(bus_out[0]));
  assert_rol_R8: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_ROL |=> bus_out[0] == $past(bus_out[W-1]));
  assert_load_R9: assert property (@(posedge clk) disable iff (!arst_n)
    mode == M_LOAD |=> bus_out == $past(bus_in));
  assert_no_drive_R10: assert property (@(posedge clk) disable iff (!arst_n)
    (mode == M_LOAD || !out_ctl) |-> !bus_oe);
endmodule

// File: tb/shift_count_reg_tb_top.sv
`timescale 1ns/1ps
module shift_count_reg_tb_top;
  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic [2:0] mode = 3'b000;
  logic       out_ctl = 1'b0;
  logic [7:0] bus_in = 8'h00;
  logic [7:0] bus_out;
  logic       bus_oe;

  int tests = 0, fails = 0;
  logic [7:0] refv = 8'h00;

  always #2.5 clk = ~clk;

  shift_count_reg #(.W(8)) dut_i (
    .clk(clk), .arst_n(arst_n), .mode(mode), .out_ctl(out_ctl),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe));

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2 hold";
      3'd1: return "R3 shift right";
      3'd2: return "R4 shift left";
      3'd3: return "R5 increment";
      3'd4: return "R6 decrement";
      3'd5: return "R7 rotate right";
      3'd6: return "R8 rotate left";
      default: return "R9 load";
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [7:0] v, input logic [2:0] m, input logic [7:0] d);
    int x;
    x = v;
    case (m)
      3'd1: x = x / 2;
      3'd2: x = (x * 2) % 256;
      3'd3: x = (x + 1) % 256;
      3'd4: x = (x + 255) % 256;
      3'd5: x = x / 2 + (x % 2) * 128;
      3'd6: x = (x * 2) % 256 + x / 128;
      3'd7: x = d;
      default: ;
    endcase
    return 8'(x);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] m, input logic oc, input logic [7:0] d);
    logic [7:0] e;
    @(negedge clk);
    mode = m; out_ctl = oc; bus_in = d;
    #1;
    check("R10 bus enable", {7'd0, bus_oe}, {7'd0, oc && (m != 3'b111)});
    e = model(refv, m, d);
    @(posedge clk); #1;
    check(tag(m), bus_out, e);
    refv = e;
  endtask

  initial begin
    #1;
    check("R1 reset state", bus_out, 8'h00);
    #20 arst_n = 1'b1;
    step(3'd7, 1'b1, 8'hFF);
    step(3'd3, 1'b0, 8'h00);
    step(3'd3, 1'b1, 8'h00);
    step(3'd4, 1'b1, 8'h00);
    step(3'd4, 1'b0, 8'h00);
    step(3'd7, 1'b0, 8'h81);
    step(3'd1, 1'b1, 8'h00);
    step(3'd7, 1'b1, 8'h81);
    step(3'd2, 1'b1, 8'h00);
    step(3'd7, 1'b0, 8'h81);
    step(3'd5, 1'b1, 8'h00);
    step(3'd6, 1'b1, 8'h00);
    step(3'd6, 1'b1, 8'h00);
    step(3'd0, 1'b1, 8'h55);
    step(3'd0, 1'b0, 8'hAA);
    for (int m = 0; m < 8; m++)
      for (int oc = 0; oc < 2; oc++)
        step(3'(m), oc[0], 8'($urandom));
    for (int i = 0; i < 2000; i++)
      step(3'($urandom), 1'($urandom), 8'($urandom));
    step(3'd7, 1'b0, 8'hC3);
    @(negedge clk);
    mode = 3'd0;
    #1 arst_n = 1'b0;
    #0.5;
    check("R1 async clear before edge", bus_out, 8'h00);
    @(negedge clk);
    #1 arst_n = 1'b1;
    refv = 8'h00;
    step(3'd3, 1'b1, 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule